// File: doc/BRIEF.md
# Double-Buffered NCO Complex Mixer

This block multiplies a stream of samples by a quadrature carrier made by a numerically controlled oscillator. A 32-bit phase accumulator advances by the active frequency word. Its upper bits address a quarter-wave sine table, and that table supplies both the sine and the cosine coefficient. The block accepts real samples, one per beat. It also accepts complex samples sent as interleaved I then Q beats. For the complex case, the complex product is spread over two output beats: I·cos with I·sin first, then −Q·sin with Q·cos. A following integrator can add the two beats together.

Software writes the frequency word into a holding register through a small write-only register port. The holding word reaches the active register only at a transfer, which is either a command write or a sync pulse when sync loading is enabled. An option clears the accumulator at the moment of transfer, so that several mixers restart in phase. Sample input and product output are valid/ready streams. A beat moves when valid and ready are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An output beat stays unchanged until `out_ready` takes it.

Top module: `nco_cmix`

## Requirements
- R1: After reset the holding word, the active word and the accumulator are zero. `out_valid` is low and `in_ready` is high, and real samples come out at phase zero (out_x equals the sample, out_y is zero).
- R2: A write to address 0 loads only the holding word. The phase step used by later samples does not change until a transfer.
- R3: A write of any data to address 1 copies the holding word into the active word at that edge. Every sample accepted after that edge uses the new step.
- R4: A high `sync_in` performs the same transfer only when control bit 2 (sync load enable) is set. Otherwise it has no effect.
- R5: When control bit 3 (zero on load) is set, a transfer clears the accumulator. The next sample uses phase zero.
- R6: The coefficient angle index is accumulator bits 31:22, which are the top 10 bits of the 24-bit truncated phase, for an angle of 2π·index/1024. Products stay within 64 output LSB of the ideal. At indices that are multiples of 256 they are exact after rounding.
- R7: With control bit 0 clear (real mode), each sample x gives out_x = x·cos and out_y = x·sin with out_second = 0. The accumulator advances once per sample.
- R8: With control bit 0 set (complex mode), a beat with `in_ifirst` high is I, and unmarked beats are dropped while waiting for I. I gives (I·cos, I·sin) with out_second = 0. Q gives (−Q·sin, Q·cos) with out_second = 1. Both use the same phase, and the accumulator advances once per pair, after Q.
- R9: With control bit 1 set in complex mode, the beat right after I is discarded and the next beat is Q.
- R10: Products are scaled by 2^-18, rounded half up, and saturated to the signed 16-bit output range.
- R11: `in_ready` = !out_valid || out_ready. While out_valid is high and out_ready low, the output beat holds steady.
- R12: Any write to the control register (address 2) returns the pair sequencer to waiting for I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0 holding word, 1 transfer, 2 control |
| cfg_wdata | input | 32 | Write data |
| sync_in | input | 1 | External transfer pulse |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 16 | Signed sample |
| in_ifirst | input | 1 | Marks the I beat in complex mode |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_x | output | 16 | Real-axis product term |
| out_y | output | 16 | Imaginary-axis product term |
| out_second | output | 1 | High on the Q beat of a complex pair |

## Verification
A wrong accumulator or active word shows up at the next output beat as a coefficient angle that does not match the one predicted from the write and transfer history. Every later beat then drifts further away. A wrong pair sequencer shows up within one pair: out_second has the wrong value, a discarded beat appears as an output, or the Q terms follow a moved phase. Rounding and saturation faults appear at the exact quarter-turn phases, where the products are known to the bit.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    PAIR_I    = 2'd0,
    PAIR_SKIP = 2'd1,
    PAIR_Q    = 2'd2
  } pair_e;

  // bit0 complex, bit1 skip after I, bit2 sync load enable, bit3 zero on load
  typedef struct packed {
    logic zero_on_load;
    logic sync_en;
    logic q_skip;
    logic cplx;
  } ctrl_t;

  localparam logic [1:0] ADDR_HOLD = 2'd0;
  localparam logic [1:0] ADDR_XFER = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  // Rational quarter-wave approximation, u in 0..n maps to 0..pi/2
  function automatic longint quarter_sine(input longint u, input longint n,
                                          input longint amax);
    longint p;
    longint den;
    p   = u * (2 * n - u);
    den = 5 * n * n - p;
    return (amax * 4 * p + den / 2) / den;
  endfunction

endpackage

// File: rtl/nco_freq_regs.sv
module nco_freq_regs
  import nco_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [FREQ_W-1:0] cfg_wdata,
  input  logic              sync_in,
  output logic [FREQ_W-1:0] freq_act,
  output ctrl_t             ctrl,
  output logic              load,
  output logic              ctrl_wr
);

  logic [FREQ_W-1:0] hold_q;
  logic [FREQ_W-1:0] act_q;
  ctrl_t             ctrl_q;
  logic              xfer_cmd;

  assign xfer_cmd = cfg_we && (cfg_addr == ADDR_XFER);
  assign load     = xfer_cmd || (sync_in && ctrl_q.sync_en);
  assign ctrl_wr  = cfg_we && (cfg_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (cfg_we && (cfg_addr == ADDR_HOLD)) hold_q <= cfg_wdata;
      if (load) act_q <= hold_q;
      if (ctrl_wr) ctrl_q <= ctrl_t'(cfg_wdata[3:0]);
    end
  end

  assign freq_act = act_q;
  assign ctrl     = ctrl_q;

  // R2
  hold_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));

  // R3
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> act_q == $past(hold_q));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FREQ_W = 32,
  parameter int ANG_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              load,
  input  logic              zero_on_load,
  input  logic [FREQ_W-1:0] freq,
  output logic [ANG_W-1:0]  angle
);

  logic [FREQ_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    acc_q <= '0;
    else if (load && zero_on_load) acc_q <= '0;
    else if (advance)              acc_q <= acc_q + freq;
  end

  assign angle = acc_q[FREQ_W-1 -: ANG_W];

  // R5
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && zero_on_load |=> acc_q == '0);

endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
  import nco_pkg::*;
#(
  parameter int LUT_AW = 8,
  parameter int AMP_W  = 19,
  localparam int ANG_W = LUT_AW + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ANG_W-1:0]        angle,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);

  localparam int     N    = 1 << LUT_AW;
  localparam longint AMAX = (longint'(1) << (AMP_W - 1)) - 1;

  logic [AMP_W-2:0] tab [N+1];

  for (genvar i = 0; i <= N; i++) begin : g_tab
    assign tab[i] = (AMP_W-1)'(quarter_sine(longint'(i), longint'(N), AMAX));
  end

  logic [1:0]        quad;
  logic [LUT_AW:0]   a_fwd;
  logic [LUT_AW:0]   a_rev;
  logic [AMP_W-2:0]  mag_s;
  logic [AMP_W-2:0]  mag_c;
  logic signed [AMP_W-1:0] ps;
  logic signed [AMP_W-1:0] pc;

  assign quad  = angle[ANG_W-1 -: 2];
  assign a_fwd = {1'b0, angle[LUT_AW-1:0]};
  assign a_rev = (LUT_AW+1)'(N) - a_fwd;

  always_comb begin
    mag_s = quad[0] ? tab[a_rev] : tab[a_fwd];
    mag_c = quad[0] ? tab[a_fwd] : tab[a_rev];
    ps    = signed'({1'b0, mag_s});
    pc    = signed'({1'b0, mag_c});
    sin_o = quad[1] ? -ps : ps;
    cos_o = (quad[1] ^ quad[0]) ? -pc : pc;
  end

  // R6
  zero_angle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    angle == '0 |-> (cos_o == AMP_W'(AMAX)) && (sin_o == '0));

endmodule

// File: rtl/nco_mult_round.sv
module nco_mult_round #(
  parameter int DATA_W = 16,
  parameter int AMP_W  = 19,
  parameter int OUT_W  = 16
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [AMP_W-1:0]  k,
  output logic signed [OUT_W-1:0]  y
);

  localparam int PW = DATA_W + AMP_W;
  localparam int SH = AMP_W - 1;
  localparam logic signed [PW:0] RND_ONE = (PW+1)'(1) << (SH - 1);
  localparam logic signed [PW:0] OMAX = (PW+1)'((longint'(1) << (OUT_W - 1)) - 1);
  localparam logic signed [PW:0] OMIN = -OMAX - (PW+1)'(1);

  logic signed [PW-1:0] prod;
  logic signed [PW:0]   rnd;
  logic signed [PW:0]   shq;

  always_comb begin
    prod = PW'(x) * PW'(k);
    rnd  = {prod[PW-1], prod} + RND_ONE;
    shq  = rnd >>> SH;
    if (shq > OMAX)      y = OMAX[OUT_W-1:0];
    else if (shq < OMIN) y = OMIN[OUT_W-1:0];
    else                 y = shq[OUT_W-1:0];
  end

endmodule

// File: rtl/nco_cmix.sv
module nco_cmix
  import nco_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int LUT_AW = 8,
  parameter int AMP_W  = 19,
  parameter int DATA_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_addr,
  input  logic [FREQ_W-1:0]        cfg_wdata,
  input  logic                     sync_in,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     in_ifirst,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_x,
  output logic signed [OUT_W-1:0]  out_y,
  output logic                     out_second
);

  localparam int ANG_W = LUT_AW + 2;

  ctrl_t             ctrl;
  logic              load;
  logic              ctrl_wr;
  logic [FREQ_W-1:0] freq;
  logic [ANG_W-1:0]  angle;
  logic signed [AMP_W-1:0] sin_v;
  logic signed [AMP_W-1:0] cos_v;

  pair_e st_q;
  pair_e st_d;
  logic  fire;
  logic  emit;
  logic  second;
  logic  adv;

  nco_freq_regs #(.FREQ_W(FREQ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sync_in(sync_in), .freq_act(freq),
    .ctrl(ctrl), .load(load), .ctrl_wr(ctrl_wr)
  );

  nco_phase_acc #(.FREQ_W(FREQ_W), .ANG_W(ANG_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .advance(fire && adv), .load(load),
    .zero_on_load(ctrl.zero_on_load), .freq(freq), .angle(angle)
  );

  nco_sincos #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_sc (
    .clk(clk), .rst_n(rst_n), .angle(angle), .sin_o(sin_v), .cos_o(cos_v)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  // Pair sequencer: decides whether a beat emits, which slot it is, and
  // whether the phase steps after it.
  always_comb begin
    st_d   = st_q;
    emit   = 1'b0;
    second = 1'b0;
    adv    = 1'b0;
    if (!ctrl.cplx) begin
      emit = 1'b1;
      adv  = 1'b1;
    end else begin
      unique case (st_q)
        PAIR_I: if (in_ifirst) begin
          emit = 1'b1;
          st_d = ctrl.q_skip ? PAIR_SKIP : PAIR_Q;
        end
        PAIR_SKIP: st_d = PAIR_Q;
        PAIR_Q: begin
          emit   = 1'b1;
          second = 1'b1;
          adv    = 1'b1;
          st_d   = PAIR_I;
        end
        default: st_d = PAIR_I;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= PAIR_I;
    else if (ctrl_wr) st_q <= PAIR_I;
    else if (fire)    st_q <= st_d;
  end

  // Two product lanes: lane 0 is the real-axis term, lane 1 the imaginary one
  logic signed [AMP_W-1:0] coef [2];
  logic signed [OUT_W-1:0] lane [2];

  assign coef[0] = second ? -sin_v : cos_v;
  assign coef[1] = second ? cos_v : sin_v;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    nco_mult_round #(.DATA_W(DATA_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_mul (
      .x(in_data), .k(coef[g]), .y(lane[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_x      <= '0;
      out_y      <= '0;
      out_second <= 1'b0;
    end else if (fire && emit) begin
      out_valid  <= 1'b1;
      out_x      <= lane[0];
      out_y      <= lane[1];
      out_second <= second;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
                                && $stable(out_second));

  // R7
  real_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ctrl.cplx |=> out_valid && !out_second);

  // R8
  pair_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ctrl.cplx && (st_q != PAIR_Q) && !load |=> $stable(angle));

endmodule

// File: tb/nco_cmix_test.sv
module nco_cmix_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               cfg_we = 1'b0;
  logic [1:0]         cfg_addr = '0;
  logic [31:0]        cfg_wdata = '0;
  logic               sync_in = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [15:0] in_data = '0;
  logic               in_ifirst = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic signed [15:0] out_x;
  logic signed [15:0] out_y;
  logic               out_second;

  nco_cmix uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sync_in(sync_in), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_ifirst(in_ifirst),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x),
    .out_y(out_y), .out_second(out_second)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Requirement model
  logic [31:0] m_acc = '0, m_hold = '0, m_act = '0;
  bit m_cplx = 0, m_skip = 0, m_sync = 0, m_zero = 0;
  int m_st = 0;

  int    qx[$], qy[$], qtol[$];
  bit    qs[$];
  string qtag[$];

  function automatic int ev(int x, real c);
    real v;
    int  r;
    v = real'(x) * c * 262143.0 / 262144.0;
    r = int'($floor(v + 0.5));
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic real cos_of(int idx);
    if (idx % 256 == 0) begin
      case (idx / 256) 0: return 1.0; 1: return 0.0; 2: return -1.0; default: return 0.0; endcase
    end
    return $cos(2.0 * 3.14159265358979 * real'(idx) / 1024.0);
  endfunction

  function automatic real sin_of(int idx);
    if (idx % 256 == 0) begin
      case (idx / 256) 0: return 0.0; 1: return 1.0; 2: return 0.0; default: return -1.0; endcase
    end
    return $sin(2.0 * 3.14159265358979 * real'(idx) / 1024.0);
  endfunction

  task automatic push(int ex, int ey, bit es, int tol, string tag);
    qx.push_back(ex); qy.push_back(ey); qs.push_back(es);
    qtol.push_back(tol); qtag.push_back(tag);
  endtask

  task automatic model_beat(int x, bit mark, string tag);
    int  idx;
    real c, s;
    int  tol;
    idx = int'(m_acc[31:22]);
    c = cos_of(idx);
    s = sin_of(idx);
    tol = (idx % 256 == 0) ? 1 : 64;
    if (!m_cplx) begin
      push(ev(x, c), ev(x, s), 1'b0, tol, tag);
      m_acc = m_acc + m_act;
    end else begin
      case (m_st)
        0: if (mark) begin
             push(ev(x, c), ev(x, s), 1'b0, tol, tag);
             m_st = m_skip ? 1 : 2;
           end
        1: m_st = 2;
        default: begin
          push(ev(x, -s), ev(x, c), 1'b1, tol, tag);
          m_acc = m_acc + m_act;
          m_st = 0;
        end
      endcase
    end
  endtask

  task automatic send(int x, bit mark, string tag);
    bit r;
    in_valid = 1'b1;
    in_data = 16'(x);
    in_ifirst = mark;
    forever begin
      @(negedge clk);
      r = in_ready;
      @(posedge clk);
      #1;
      if (r) break;
    end
    in_valid = 1'b0;
    in_ifirst = 1'b0;
    model_beat(x, mark, tag);
  endtask

  task automatic cfg(logic [1:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    case (a)
      2'd0: m_hold = d;
      2'd1: begin m_act = m_hold; if (m_zero) m_acc = '0; end
      2'd2: begin
        m_cplx = d[0]; m_skip = d[1]; m_sync = d[2]; m_zero = d[3]; m_st = 0;
      end
      default: ;
    endcase
  endtask

  task automatic pulse_sync();
    sync_in = 1'b1;
    @(posedge clk);
    #1;
    sync_in = 1'b0;
    if (m_sync) begin m_act = m_hold; if (m_zero) m_acc = '0; end
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Output monitor: every handshaken output beat is compared in order
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (qx.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected beat actual x=%0d y=%0d s=%0d expected none",
                 out_x, out_y, out_second);
      end else begin
        int ex, ey, tol;
        bit es;
        string tg;
        ex = qx.pop_front(); ey = qy.pop_front(); es = qs.pop_front();
        tol = qtol.pop_front(); tg = qtag.pop_front();
        if ((int'(out_x) - ex > tol) || (ex - int'(out_x) > tol) ||
            (int'(out_y) - ey > tol) || (ey - int'(out_y) > tol) ||
            (out_second != es)) begin
          errors++;
          $display("FAIL %s actual x=%0d y=%0d s=%0d expected x=%0d y=%0d s=%0d",
                   tg, out_x, out_y, out_second, ex, ey, es);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    send(1000, 0, "R1"); send(-1000, 0, "R1"); send(12345, 0, "R1");

    // R2: holding write alone leaves the step unchanged
    cfg(2'd0, 32'h4000_0000);
    for (int k = 0; k < 4; k++) send(3000 + k, 0, "R2");

    // R3: transfer command, quarter-turn steps (exact points)
    cfg(2'd1, 32'h0);
    for (int k = 0; k < 8; k++) send(20000 - 5000 * k, 0, "R3");

    // R10: saturation and rounding at exact phases
    for (int k = 0; k < 8; k++) send(-32768, 0, "R10");
    for (int k = 0; k < 4; k++) send(32767, 0, "R10");
    for (int k = 0; k < 4; k++) send(-3, 0, "R10");

    // R6 / R7: real-mode sweeps over several steps
    begin
      logic [31:0] fl [4];
      fl[0] = 32'h0123_4567; fl[1] = 32'hFFC0_0000;
      fl[2] = 32'h0800_0001; fl[3] = 32'h2AAA_AAAB;
      for (int f = 0; f < 4; f++) begin
        cfg(2'd0, fl[f]);
        cfg(2'd1, 32'h0);
        for (int k = 0; k < 48; k++)
          send(((k * 7919 + f * 1237) % 60000) - 30000, 0, "R6 R7");
      end
    end

    // R4: sync ignored when disabled, honoured when enabled
    cfg(2'd2, 32'h0);
    cfg(2'd0, 32'h4000_0000);
    pulse_sync();
    for (int k = 0; k < 6; k++) send(10000, 0, "R4 off");
    cfg(2'd2, 32'h4);
    pulse_sync();
    for (int k = 0; k < 6; k++) send(10000, 0, "R4 on");

    // R5: zero on load
    cfg(2'd2, 32'hC);
    cfg(2'd0, 32'h1234_5678);
    cfg(2'd1, 32'h0);
    for (int k = 0; k < 3; k++) send(15000, 0, "R5 pre");
    cfg(2'd1, 32'h0);
    for (int k = 0; k < 5; k++) send(15000, 0, "R5");
    cfg(2'd0, 32'h0300_0000);
    for (int k = 0; k < 2; k++) send(9000, 0, "R5 pre");
    pulse_sync();
    for (int k = 0; k < 4; k++) send(9000, 0, "R5 sync");

    // R8: complex pairs, unmarked beat dropped while waiting for I
    cfg(2'd2, 32'h1);
    cfg(2'd0, 32'h0C00_0000);
    cfg(2'd1, 32'h0);
    send(4444, 0, "R8 drop");
    for (int k = 0; k < 16; k++) begin
      send(((k * 4001) % 50000) - 25000, 1, "R8 I");
      send(((k * 6007) % 50000) - 25000, 0, "R8 Q");
    end

    // R9: one beat skipped between I and Q
    cfg(2'd2, 32'h3);
    for (int k = 0; k < 12; k++) begin
      send(((k * 3001) % 40000) - 20000, 1, "R9 I");
      send(31000, 0, "R9 skip");
      send(((k * 5003) % 40000) - 20000, 0, "R9 Q");
    end

    // R12: control write mid-pair returns to waiting for I
    cfg(2'd2, 32'h1);
    send(7000, 1, "R12 I");
    cfg(2'd2, 32'h1);
    send(777, 0, "R12 drop");
    send(8000, 1, "R12 I");
    send(-8000, 0, "R12 Q");

    // R11: back-pressure
    cfg(2'd2, 32'h0);
    out_ready = 1'b0;
    send(12000, 0, "R11");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R11 in_ready low", int'(in_ready), 0);
      check(out_valid == 1'b1, "R11 out_valid held", int'(out_valid), 1);
    end
    @(posedge clk);
    #1;
    out_ready = 1'b1;
    send(-12000, 0, "R11");

    repeat (4) @(posedge clk);
    #1;
    check(qx.size() == 0, "R8 pending beats", qx.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule